// File: doc/BRIEF.md
# Four-Channel Overcurrent Retry and Open-Load Fault Sequencer

This block sits between the output command register of a low-side power switch and the gate drivers of its four channels. Each channel takes a requested on/off state, an overcurrent comparator flag and an open-load comparator flag. It produces the gate enable that actually reaches the switch and two live fault flags. A shared prescaler divides the system clock into a slow tick. The tick stands in for the externally set oscillator, and every protection timer counts in ticks.

An overcurrent seen while a channel conducts turns the gate off at once. The channel then enters a retry loop. A long rest period with the gate off is followed by a short probe window with the gate back on, where the current is sensed again. The loop repeats until one probe window passes without the comparator firing, and the channel then resumes normal conduction. With the default timings the retry duty is about 1.56 %. Open load is judged only while a channel is commanded off, and it must persist for a qualifying time before it is flagged. A supply lockout input forces every gate off.

Top module: `ovc_guard`

## Requirements
- R1: While rst_n is low at a clock edge, every gate_en, oc_fault and open_fault bit is 0 after that edge.
- R2: When a channel is commanded on and has no fault and no lockout, gate_en goes to 1 after the next clock edge. When the command drops, gate_en goes to 0 after the next clock edge.
- R3: If oc_flag is 1 while the gate is on (in normal conduction or in a probe window), gate_en is 0 and oc_fault is 1 after the next edge.
- R4: After an overcurrent the gate stays off until SHUT_TICKS ticks have been counted. It is then on for a probe window of SENSE_TICKS ticks, and an overcurrent during the probe restarts the rest period.
- R5: A probe window that ends with oc_flag low for its whole length returns the channel to normal conduction and clears oc_fault.
- R6: oc_flag has no effect while the channel is off, whether it is commanded off or resting. A channel that is off with oc_fault low keeps oc_fault low.
- R7: open_fault is set once open_flag has been high for OPEN_TICKS ticks while the channel is commanded off. It clears after the first edge at which open_flag is low or the channel is commanded on.
- R8: While lockout is 1, every gate_en bit is 0 in the same cycle. After an edge with lockout high, every channel is off and oc_fault is 0.
- R9: A command of off in any state sends the channel to off after the next edge and clears oc_fault.
- R10: The channels are independent: one channel's inputs never change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_on | input | NCH | Requested on state per channel |
| oc_flag | input | NCH | Overcurrent comparator output per channel |
| open_flag | input | NCH | Open-load comparator output per channel (drain above half supply) |
| lockout | input | 1 | Supply over/undervoltage lockout, forces all gates off |
| gate_en | output | NCH | Gate enable per channel |
| oc_fault | output | NCH | Live overcurrent fault per channel |
| open_fault | output | NCH | Qualified open-load fault per channel |

## Verification
Within one cycle, a channel can see an overcurrent during a probe window and also a command to turn off or a lockout. In that case the off command must win, and oc_fault must clear rather than the channel going back to rest. The random stimulus toggles cmd_on, oc_flag and lockout independently with probabilities that keep probe windows frequent, so these collisions happen many times. A directed step also drops the command while a channel is resting with its fault set. A cycle-level reference model in the bench judges every output on every cycle, so a wrong priority shows up as a gate or fault mismatch in that cycle.

// File: rtl/ovg_pkg.sv
// Shared types for the overcurrent retry sequencer.
package ovg_pkg;
    // Per-channel protection state.
    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ON    = 2'd1,
        CH_REST  = 2'd2,
        CH_PROBE = 2'd3
    } ch_state_t;
endpackage

// File: rtl/ovg_tick.sv
// Prescaler: emits a one-cycle tick every PRESCALE clocks.
// Assumes PRESCALE >= 1. The first tick follows reset release by PRESCALE clocks.
module ovg_tick #(
    parameter int PRESCALE = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE == 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            logic [CW-1:0] cnt;
            // Wrap counter that defines the tick period.
            always_ff @(posedge clk) begin
                if (!rst_n)                         cnt <= '0;
                else if (cnt == CW'(PRESCALE - 1))  cnt <= '0;
                else                                cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == CW'(PRESCALE - 1));
        end
    endgenerate
endmodule

// File: rtl/ovg_retry_fsm.sv
// One channel's overcurrent sequencer: normal conduction, then a loop of
// rest (gate off) and probe (gate on) windows after an overcurrent.
// Assumes SENSE_TICKS >= 1, SHUT_TICKS >= 1, and a single-cycle tick.
module ovg_retry_fsm
    import ovg_pkg::*;
#(
    parameter int SENSE_TICKS = 16,
    parameter int SHUT_TICKS  = 1008
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_on,
    input  logic oc_flag,
    input  logic lockout,
    output logic gate_en,
    output logic oc_fault
);
    localparam int TMAX = (SHUT_TICKS > SENSE_TICKS) ? SHUT_TICKS : SENSE_TICKS;
    localparam int TW   = $clog2(TMAX + 1);

    ch_state_t      st;
    logic [TW-1:0]  tmr;

    // State, window timer and fault flag update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= CH_OFF;
            tmr      <= '0;
            oc_fault <= 1'b0;
        end else if (!cmd_on || lockout) begin
            st       <= CH_OFF;
            tmr      <= '0;
            oc_fault <= 1'b0;
        end else begin
            case (st)
                CH_OFF: st <= CH_ON;
                CH_ON: begin
                    if (oc_flag) begin
                        st       <= CH_REST;
                        tmr      <= '0;
                        oc_fault <= 1'b1;
                    end
                end
                CH_REST: begin
                    if (tick) begin
                        if (tmr == TW'(SHUT_TICKS - 1)) begin
                            st  <= CH_PROBE;
                            tmr <= '0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                CH_PROBE: begin
                    if (oc_flag) begin
                        st  <= CH_REST;
                        tmr <= '0;
                    end else if (tick) begin
                        if (tmr == TW'(SENSE_TICKS - 1)) begin
                            st       <= CH_ON;
                            tmr      <= '0;
                            oc_fault <= 1'b0;
                        end else begin
                            tmr <= tmr + 1'b1;
                        end
                    end
                end
                default: st <= CH_OFF;
            endcase
        end
    end

    // Gate follows the conducting states, forced low by lockout.
    assign gate_en = ((st == CH_ON) || (st == CH_PROBE)) && !lockout;
endmodule

// File: rtl/ovg_open_qual.sv
// One channel's open-load qualifier: counts ticks while commanded off
// with the open-load comparator high; flags once OPEN_TICKS are reached.
// Assumes OPEN_TICKS >= 1.
module ovg_open_qual #(
    parameter int OPEN_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_on,
    input  logic open_flag,
    output logic open_fault
);
    localparam int QW = $clog2(OPEN_TICKS + 1);

    logic [QW-1:0] qcnt;

    // Saturating persistence counter, cleared when the condition lapses.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_on || !open_flag) qcnt <= '0;
        else if (tick && (qcnt != QW'(OPEN_TICKS))) qcnt <= qcnt + 1'b1;
    end

    assign open_fault = (qcnt == QW'(OPEN_TICKS));
endmodule

// File: rtl/ovc_guard.sv
// Top: shared tick prescaler plus NCH independent protection channels.
// Assumes comparator flags are already synchronous to clk.
module ovc_guard #(
    parameter int NCH         = 4,
    parameter int PRESCALE    = 64,
    parameter int SENSE_TICKS = 16,
    parameter int SHUT_TICKS  = 1008,
    parameter int OPEN_TICKS  = 25
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] cmd_on,
    input  logic [NCH-1:0] oc_flag,
    input  logic [NCH-1:0] open_flag,
    input  logic           lockout,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] oc_fault,
    output logic [NCH-1:0] open_fault
);
    logic tick;

    ovg_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            ovg_retry_fsm #(.SENSE_TICKS(SENSE_TICKS), .SHUT_TICKS(SHUT_TICKS)) u_fsm (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .cmd_on(cmd_on[c]), .oc_flag(oc_flag[c]), .lockout(lockout),
                .gate_en(gate_en[c]), .oc_fault(oc_fault[c])
            );
            ovg_open_qual #(.OPEN_TICKS(OPEN_TICKS)) u_open (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .cmd_on(cmd_on[c]), .open_flag(open_flag[c]),
                .open_fault(open_fault[c])
            );
        end
    endgenerate
endmodule

// File: rtl/ovg_guard_chk.sv
// Port-level protocol checks for ovc_guard, attached by bind.
module ovg_guard_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] cmd_on,
    input logic [NCH-1:0] oc_flag,
    input logic [NCH-1:0] open_flag,
    input logic           lockout,
    input logic [NCH-1:0] gate_en,
    input logic [NCH-1:0] oc_fault,
    input logic [NCH-1:0] open_fault
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_c
            // R3
            oc_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gate_en[c] && oc_flag[c] && cmd_on[c] && !lockout) |=> (!gate_en[c] && oc_fault[c]));
            // R9
            cmd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !cmd_on[c] |=> (!gate_en[c] && !oc_fault[c]));
            // R8
            lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lockout |-> !gate_en[c]);
            // R8
            lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                lockout |=> !oc_fault[c]);
            // R6
            off_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!gate_en[c] && !oc_fault[c]) |=> !oc_fault[c]);
            // R7
            open_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_on[c] || !open_flag[c]) |=> !open_fault[c]);
        end
    endgenerate
endmodule

bind ovc_guard ovg_guard_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/sim_ovc_guard.sv
module sim_ovc_guard;
    localparam int NCH = 4, PRE = 2, SENSE = 4, SHUT = 12, OPEN = 3;

    logic clk = 0, rst_n = 0, lockout = 0;
    logic [NCH-1:0] cmd_on = '0, oc_flag = '0, open_flag = '0;
    logic [NCH-1:0] gate_en, oc_fault, open_fault;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // Reference model (bench-side encoding: 0 off, 1 on, 2 rest, 3 probe)
    int m_pc = 0;
    int m_st[NCH], m_t[NCH], m_q[NCH];
    bit m_f[NCH];

    ovc_guard #(.NCH(NCH), .PRESCALE(PRE), .SENSE_TICKS(SENSE),
                .SHUT_TICKS(SHUT), .OPEN_TICKS(OPEN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .oc_flag(oc_flag),
        .open_flag(open_flag), .lockout(lockout), .gate_en(gate_en),
        .oc_fault(oc_fault), .open_fault(open_fault));

    always #4 clk = ~clk;

    initial foreach (m_st[i]) begin m_st[i] = 0; m_t[i] = 0; m_q[i] = 0; m_f[i] = 0; end

    always @(posedge clk) begin
        bit tk;
        if (!rst_n) begin
            m_pc = 0;
            for (int i = 0; i < NCH; i++) begin m_st[i] = 0; m_t[i] = 0; m_q[i] = 0; m_f[i] = 0; end
        end else begin
            tk = (m_pc == PRE - 1);
            m_pc = tk ? 0 : m_pc + 1;
            for (int i = 0; i < NCH; i++) begin
                if (!cmd_on[i] || lockout) begin m_st[i] = 0; m_t[i] = 0; m_f[i] = 0; end
                else if (m_st[i] == 0) m_st[i] = 1;
                else if (m_st[i] == 1) begin
                    if (oc_flag[i]) begin m_st[i] = 2; m_t[i] = 0; m_f[i] = 1; end
                end else if (m_st[i] == 2) begin
                    if (tk) begin m_t[i]++; if (m_t[i] == SHUT) begin m_st[i] = 3; m_t[i] = 0; end end
                end else begin
                    if (oc_flag[i]) begin m_st[i] = 2; m_t[i] = 0; end
                    else if (tk) begin
                        m_t[i]++;
                        if (m_t[i] == SENSE) begin m_st[i] = 1; m_t[i] = 0; m_f[i] = 0; end
                    end
                end
                if (cmd_on[i] || !open_flag[i]) m_q[i] = 0;
                else if (tk && m_q[i] < OPEN) m_q[i]++;
            end
        end
    end

    function automatic bit exp_gate(int i);
        return (m_st[i] == 1 || m_st[i] == 3) && !lockout;
    endfunction

    task automatic check(string tag, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance one cycle and compare all outputs with the model.
    task automatic step();
        @(posedge clk); @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            check("R4 gate vs model", gate_en[i], exp_gate(i));
            check("R5 oc_fault vs model", oc_fault[i], m_f[i]);
            check("R7 open_fault vs model", open_fault[i], m_q[i] == OPEN);
        end
    endtask

    task automatic wait_n(int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        @(negedge clk);
        wait_n(3);
        check("R1 gate reset", gate_en[0] | gate_en[3], 1'b0);
        check("R1 faults reset", |{oc_fault, open_fault}, 1'b0);
        rst_n = 1;
        wait_n(2);
        // R2 turn on
        cmd_on = 4'b0011;
        step();
        check("R2 gate on", gate_en[0], 1'b1);
        // R3 overcurrent trips; R10 neighbour unaffected
        oc_flag[0] = 1;
        step();
        check("R3 gate off", gate_en[0], 1'b0);
        check("R3 fault set", oc_fault[0], 1'b1);
        check("R10 ch1 gate", gate_en[1], 1'b1);
        check("R10 ch1 fault", oc_fault[1], 1'b0);
        wait_n(60);
        check("R4 fault persists", oc_fault[0], 1'b1);
        oc_flag[0] = 0;
        wait_n(SHUT * PRE + SENSE * PRE + 8);
        check("R5 back on", gate_en[0], 1'b1);
        check("R5 fault cleared", oc_fault[0], 1'b0);
        // R6 overcurrent while commanded off
        oc_flag[2] = 1;
        wait_n(5);
        check("R6 no fault off", oc_fault[2], 1'b0);
        check("R6 gate off", gate_en[2], 1'b0);
        oc_flag[2] = 0;
        // R9 command off while resting
        oc_flag[0] = 1;
        wait_n(3);
        cmd_on[0] = 0;
        step();
        check("R9 fault cleared", oc_fault[0], 1'b0);
        check("R9 gate off", gate_en[0], 1'b0);
        oc_flag[0] = 0;
        // R8 lockout, same cycle
        lockout = 1;
        #1;
        check("R8 gate forced off", gate_en[1], 1'b0);
        step();
        lockout = 0;
        step(); step();
        check("R8 resumes after lockout", gate_en[1], 1'b1);
        // R7 open-load qualification
        open_flag[3] = 1;
        step();
        check("R7 not yet", open_fault[3], 1'b0);
        wait_n(OPEN * PRE + 2);
        check("R7 set", open_fault[3], 1'b1);
        open_flag[3] = 0;
        step();
        check("R7 cleared", open_fault[3], 1'b0);
        // Random phase
        for (int n = 0; n < 20000; n++) begin
            for (int i = 0; i < NCH; i++) begin
                if ($urandom % 40 == 0) cmd_on[i] = ~cmd_on[i];
                if ($urandom % 15 == 0) oc_flag[i] = ~oc_flag[i];
                if ($urandom % 20 == 0) open_flag[i] = ~open_flag[i];
            end
            if ($urandom % 300 == 0) lockout = ~lockout;
            step();
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule